// File: doc/BRIEF.md
# Serial Autobaud Lock Engine

This block finds the bit rate of an asynchronous 8N1 serial host with no prior setting. While it is measuring, the host repeats the byte 0x00. The line then stays low for nine bit times in a row: the start bit and eight zero data bits. The block counts that low run in system-clock cycles and turns the count into a bit period, rounded to the nearest cycle. It then sends one 0x00 byte back at that rate to tell the host that the adjustment is done.

Next the block listens for the host's confirmation. Only a correctly framed 0x55 locks the block. Once locked, it shows the derived divisor to the logic that follows, and that logic uses the divisor for all later traffic. Any other byte sends the block back to measuring. So does a quiet period longer than a programmable number of bit times.

The RX input passes through a two-flop synchronizer. The receiver samples each bit at its centre, and the transmitter and the receiver both use the same derived divisor.

Top module: `autobaud_lock`

## Requirements
- R1: After reset, `tx_o` is 1, `locked_o` is 0 and `baud_div_o` is 0.
- R2: A low run of L cycles on `rx_i`, with L inside the accepted window, gives a divisor D = floor((L + 4) / 9). The block then sends 0x00 on `tx_o` in 8N1 format, LSB first, with D cycles per bit. This shows as exactly 9·D low cycles followed by a high stop bit.
- R3: A low run shorter than MIN_LOW or longer than MAX_LOW cycles produces no acknowledgement. The low counter saturates at 2^CNT_W − 1, so a very long low never wraps back into the accepted window.
- R4: When the received byte after the acknowledgement is 0x55 with a high stop bit, `locked_o` rises after the stop bit is sampled and `baud_div_o` shows D. `locked_o` is still 0 while the frame's data bits are in progress.
- R5: Any other received byte leaves `locked_o` at 0 and returns the block to measuring, so a new zero byte gives a new acknowledgement at the newly measured rate.
- R6: After the acknowledgement, if no start bit arrives within `timeout_bits_i` bit periods, the block returns to measuring. A start bit that arrives inside that window is received normally.
- R7: Once locked, the block ignores `rx_i`. `tx_o` stays high, `locked_o` stays 1 and `baud_div_o` does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial input from the host |
| timeout_bits_i | input | TMO_W | Confirmation timeout, in bit periods |
| tx_o | output | 1 | Serial output to the host (idle high) |
| locked_o | output | 1 | High once the 0x55 confirmation has been received |
| baud_div_o | output | DIV_W | Bit period in clock cycles, valid while locked |

## Verification
The acknowledgement starts about four cycles after `rx_i` goes high: two cycles in the synchronizer, one in the measurement and one in the sequencer. The bench therefore does not predict the exact start cycle. It waits for `tx_o` to fall and then counts the low cycles, sampling on the falling clock edge, and checks the count against 9·D. `locked_o` is due about 2 + D/2 + 9·D cycles after the confirmation's start edge. The bench samples it once at 9·D, where it must still be 0, and again six cycles after the end of the stop bit, where it must be 1. For the cases where nothing should happen, the bench watches `tx_o` for a window much longer than the four-cycle latency.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  typedef enum logic [1:0] {
    ST_MEASURE,
    ST_ACK,
    ST_CONFIRM,
    ST_LOCKED
  } ab_state_e;

  localparam logic [7:0] CONFIRM_BYTE = 8'h55;
  localparam logic [7:0] ACK_BYTE     = 8'h00;
endpackage

// File: rtl/autobaud_synchronizer.sv
module autobaud_synchronizer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/autobaud_measure.sv
module autobaud_measure #(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 12,
  parameter int MIN_LOW = 7000,
  parameter int MAX_LOW = 25000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rx_i,
  output logic             valid_o,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LO_LIM  = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] HI_LIM  = CNT_W'(MAX_LOW);
  localparam int DIV_LO = (MIN_LOW + 4) / 9;
  localparam int DIV_HI = (MAX_LOW + 4) / 9;

  logic             rx_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   rnd_sum;
  logic [CNT_W:0]   rnd_quo;

  assign rnd_sum = {1'b0, cnt} + (CNT_W+1)'(4);
  assign rnd_quo = rnd_sum / (CNT_W+1)'(9);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= 1'b1;
      armed   <= 1'b0;
      cnt     <= '0;
      valid_o <= 1'b0;
      div_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      rx_q    <= rx_i;
      if (!en_i) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (!armed) begin
        armed <= rx_i;
        cnt   <= '0;
      end else if (!rx_i) begin
        if (rx_q)                cnt <= CNT_W'(1);
        else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end else if (!rx_q) begin
        if (cnt >= LO_LIM && cnt <= HI_LIM) begin
          valid_o <= 1'b1;
          div_o   <= DIV_W'(rnd_quo);
        end
        cnt <= '0;
      end
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (en_i && armed && !rx_i && !rx_q && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R3
  AST_DIV_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (div_o >= DIV_W'(DIV_LO) && div_o <= DIV_W'(DIV_HI))); // R3
endmodule

// File: rtl/autobaud_tx.sv
module autobaud_tx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             line_o,
  output logic             busy_o
);
  logic [8:0]       shreg;
  logic [3:0]       left;
  logic [DIV_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= 1'b1;
      busy_o <= 1'b0;
      shreg  <= '1;
      left   <= '0;
      bcnt   <= '0;
    end else if (!busy_o) begin
      line_o <= 1'b1;
      if (start_i) begin
        busy_o <= 1'b1;
        line_o <= 1'b0;
        shreg  <= {1'b1, data_i};
        left   <= 4'd9;
        bcnt   <= div_i - DIV_W'(1);
      end
    end else if (bcnt != '0) begin
      bcnt <= bcnt - DIV_W'(1);
    end else if (left == '0) begin
      busy_o <= 1'b0;
      line_o <= 1'b1;
    end else begin
      line_o <= shreg[0];
      shreg  <= {1'b1, shreg[8:1]};
      left   <= left - 4'd1;
      bcnt   <= div_i - DIV_W'(1);
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> line_o); // R2
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             valid_o,
  output logic             ok_o,
  output logic [7:0]       data_o,
  output logic             busy_o
);
  logic             rx_q;
  logic [3:0]       idx;
  logic [DIV_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= 1'b1;
      idx     <= '0;
      bcnt    <= '0;
      valid_o <= 1'b0;
      ok_o    <= 1'b0;
      data_o  <= '0;
      busy_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      rx_q    <= rx_i;
      if (!en_i) begin
        busy_o <= 1'b0;
      end else if (!busy_o) begin
        if (rx_q && !rx_i) begin
          busy_o <= 1'b1;
          idx    <= '0;
          bcnt   <= div_i >> 1;
        end
      end else if (bcnt != '0) begin
        bcnt <= bcnt - DIV_W'(1);
      end else begin
        bcnt <= div_i - DIV_W'(1);
        if (idx == 4'd0) begin
          if (rx_i) busy_o <= 1'b0;
          else      idx    <= 4'd1;
        end else if (idx == 4'd9) begin
          valid_o <= 1'b1;
          ok_o    <= rx_i;
          busy_o  <= 1'b0;
        end else begin
          data_o <= {rx_i, data_o[7:1]};
          idx    <= idx + 4'd1;
        end
      end
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
endmodule

// File: rtl/autobaud_lock.sv
module autobaud_lock
  import autobaud_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 12,
  parameter int TMO_W   = 8,
  parameter int MIN_LOW = 7000,
  parameter int MAX_LOW = 25000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic [TMO_W-1:0] timeout_bits_i,
  output logic             tx_o,
  output logic             locked_o,
  output logic [DIV_W-1:0] baud_div_o
);
  ab_state_e        state;
  logic             rx_s;
  logic             meas_valid;
  logic [DIV_W-1:0] meas_div;
  logic [DIV_W-1:0] div_reg;
  logic             ack_go;
  logic             tx_busy;
  logic             rx_valid, rx_ok, rx_busy;
  logic [7:0]       rx_byte;
  logic [DIV_W-1:0] tick_cnt;
  logic [TMO_W-1:0] tmo_cnt;

  autobaud_synchronizer #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s)
  );

  autobaud_measure #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)
  ) u_meas (
    .clk(clk), .rst(rst), .en_i(state == ST_MEASURE), .rx_i(rx_s),
    .valid_o(meas_valid), .div_o(meas_div)
  );

  autobaud_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .start_i(state == ST_ACK && !ack_go),
    .data_i(ACK_BYTE), .div_i(div_reg), .line_o(tx_o), .busy_o(tx_busy)
  );

  autobaud_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .en_i(state == ST_CONFIRM), .rx_i(rx_s),
    .div_i(div_reg), .valid_o(rx_valid), .ok_o(rx_ok), .data_o(rx_byte),
    .busy_o(rx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_MEASURE;
      div_reg    <= '0;
      ack_go     <= 1'b0;
      tick_cnt   <= '0;
      tmo_cnt    <= '0;
      locked_o   <= 1'b0;
      baud_div_o <= '0;
    end else begin
      unique case (state)
        ST_MEASURE: begin
          if (meas_valid) begin
            div_reg <= meas_div;
            ack_go  <= 1'b0;
            state   <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (!ack_go) begin
            ack_go <= 1'b1;
          end else if (!tx_busy) begin
            tick_cnt <= '0;
            tmo_cnt  <= '0;
            state    <= ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          if (rx_valid) begin
            if (rx_ok && rx_byte == CONFIRM_BYTE) begin
              locked_o   <= 1'b1;
              baud_div_o <= div_reg;
              state      <= ST_LOCKED;
            end else begin
              state <= ST_MEASURE;
            end
          end else if (rx_busy) begin
            tick_cnt <= '0;
            tmo_cnt  <= '0;
          end else if (tick_cnt == div_reg - DIV_W'(1)) begin
            tick_cnt <= '0;
            if (tmo_cnt == timeout_bits_i - TMO_W'(1)) state <= ST_MEASURE;
            else tmo_cnt <= tmo_cnt + TMO_W'(1);
          end else begin
            tick_cnt <= tick_cnt + DIV_W'(1);
          end
        end
        default: state <= ST_LOCKED;
      endcase
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o); // R7
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(baud_div_o)); // R7
  AST_TX_QUIET_LOCKED: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> tx_o); // R7
  AST_LOCK_NEEDS_55: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(rx_valid && rx_ok && rx_byte == CONFIRM_BYTE)); // R4
endmodule

// File: tb/autobaud_lock_tb.sv
module autobaud_lock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT        = 20;
  localparam int CNT_W      = 10;
  localparam int DIV_W      = 8;
  localparam int TMO_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx  = 1'b1;
  logic [TMO_W-1:0] tmo = 8'd8;
  logic             tx;
  logic             locked;
  logic [DIV_W-1:0] div;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_lock #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .TMO_W(TMO_W), .MIN_LOW(90), .MAX_LOW(400)
  ) u_dut (
    .clk(clk), .rst(rst), .rx_i(rx), .timeout_bits_i(tmo),
    .tx_o(tx), .locked_o(locked), .baud_div_o(div)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx  = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_low(input int len);
    @(negedge clk) rx = 1'b0;
    repeat (len) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic wait_tx_low(input int maxwait, output int len);
    int w;
    w   = 0;
    len = 0;
    while (tx === 1'b1 && w < maxwait) begin
      @(negedge clk);
      w++;
    end
    if (tx === 1'b0) begin
      while (tx === 1'b0 && len < 4000) begin
        @(negedge clk);
        len++;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int bc, output bit lk_mid);
    @(negedge clk) rx = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bc) @(negedge clk);
    end
    lk_mid = locked;
    rx = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(tx == 1'b1, "R1 tx idle", int'(tx), 1);
    check(locked == 1'b0, "R1 locked", int'(locked), 0);
    check(div == '0, "R1 divisor", int'(div), 0);
  endtask

  task automatic t_lock_and_hold();
    int len;
    bit mid;
    do_reset();
    send_low(9 * BIT);
    wait_tx_low(100, len);
    check(len == 9 * BIT, "R2 ack low run", len, 9 * BIT);
    repeat (2 * BIT) @(negedge clk);
    send_byte(8'h55, BIT, mid);
    check(mid == 1'b0, "R4 locked early", int'(mid), 0);
    repeat (6) @(negedge clk);
    check(locked == 1'b1, "R4 locked", int'(locked), 1);
    check(div == DIV_W'(BIT), "R4 divisor", int'(div), BIT);
    send_low(9 * BIT);
    wait_tx_low(300, len);
    check(len == 0, "R7 no ack when locked", len, 0);
    check(locked == 1'b1, "R7 locked held", int'(locked), 1);
    check(div == DIV_W'(BIT), "R7 divisor held", int'(div), BIT);
  endtask

  task automatic t_rounding();
    int len;
    bit mid;
    do_reset();
    send_low(184);
    wait_tx_low(100, len);
    check(len == 180, "R2 round down", len, 180);
    do_reset();
    send_low(185);
    wait_tx_low(100, len);
    check(len == 189, "R2 round up", len, 189);
    repeat (42) @(negedge clk);
    send_byte(8'h55, 21, mid);
    repeat (6) @(negedge clk);
    check(div == DIV_W'(21), "R2 rounded divisor", int'(div), 21);
  endtask

  task automatic t_reject();
    int len;
    do_reset();
    send_low(89);
    wait_tx_low(300, len);
    check(len == 0, "R3 below window", len, 0);
    send_low(401);
    wait_tx_low(300, len);
    check(len == 0, "R3 above window", len, 0);
    send_low(1200);
    wait_tx_low(300, len);
    check(len == 0, "R3 saturation no wrap", len, 0);
    send_low(90);
    wait_tx_low(100, len);
    check(len == 90, "R3 window edge accepted", len, 90);
  endtask

  task automatic t_wrong_byte();
    int len;
    bit mid;
    do_reset();
    send_low(9 * BIT);
    wait_tx_low(100, len);
    repeat (2 * BIT) @(negedge clk);
    send_byte(8'h54, BIT, mid);
    repeat (6) @(negedge clk);
    check(locked == 1'b0, "R5 wrong byte no lock", int'(locked), 0);
    send_low(243);
    wait_tx_low(100, len);
    check(len == 243, "R5 remeasured ack", len, 243);
    repeat (54) @(negedge clk);
    send_byte(8'h55, 27, mid);
    repeat (6) @(negedge clk);
    check(locked == 1'b1 && div == DIV_W'(27), "R5 relock divisor", int'(div), 27);
  endtask

  task automatic t_timeout();
    int len;
    bit mid;
    do_reset();
    send_low(9 * BIT);
    wait_tx_low(100, len);
    repeat (6 * BIT) @(negedge clk);
    send_byte(8'h55, BIT, mid);
    repeat (6) @(negedge clk);
    check(locked == 1'b1, "R6 inside window", int'(locked), 1);
    do_reset();
    send_low(9 * BIT);
    wait_tx_low(100, len);
    repeat (12 * BIT) @(negedge clk);
    check(locked == 1'b0, "R6 expired no lock", int'(locked), 0);
    send_low(9 * BIT);
    wait_tx_low(100, len);
    check(len == 9 * BIT, "R6 back to measuring", len, 9 * BIT);
  endtask

  initial begin
    t_reset();
    t_lock_and_hold();
    t_rounding();
    t_reject();
    t_wrong_byte();
    t_timeout();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule